// File: doc/BRIEF.md
# Eight-Bit Host Bus Access Controller

This block is a single-select master for an external 8-bit host bus. An internal client supplies an address, a write byte and a direction, and the block runs one bus access. Each access has a one-clock address phase with the address-latch strobe active, then a data phase of programmable length with the read or write strobe active. A one-clock done pulse returns the access to the client, together with the captured byte for reads. The byte lane `ad_o/ad_oe/ad_i` carries the multiplexed address/data in the multiplexed sub-mode, and the data alone in the split sub-modes. `addr_o` always presents the full latched address.

A set of per-select inputs (strobe polarities, read and write wait-state codes, one-clock trims and sub-mode) takes effect only while `cs_cfg_en` is high. While it is low, the global sub-mode is used with the default timing and polarity. The configuration is sampled when a request is accepted. In the streaming read sub-mode the read strobe stays active between consecutive reads, and only the address moves.

States: `ST_IDLE` (waiting; IDLE->ADDR on an accepted request), `ST_ADDR` (one clock, latch strobe active; ADDR->DATA always), `ST_DATA` (strobe active for the programmed width; DATA->DONE on the last clock), `ST_DONE` (done pulse; DONE->IDLE always).

Top module: `hb8_ctrl`

## Requirements
- R1: After reset the block is idle. `busy`=0, `done`=0, `ad_oe`=0, `rd_o`=1, `wr_o`=1 and `ale_o`=0, which are the inactive levels of the default polarities.
- R2: A request is accepted only in the idle state. A `req_valid` pulse while busy starts no access, and `busy` is 0 on the clock after the done pulse.
- R3: The latch strobe is active for exactly one clock, the first clock after acceptance. During that clock `addr_o` equals the request address. In sub-mode 0 (multiplexed), `ad_oe`=1 and `ad_o` equals address bits 7:0.
- R4: The data-phase strobe is active for 2*(code+1)-trim clocks. The 2-bit code is `cs_rd_ws` for reads and `cs_wr_ws` for writes, and the trim bit is `cs_rd_trim` or `cs_wr_trim` (1 removes one clock).
- R5: The polarity bits select the active level of each strobe: `cs_ale_hi` for the latch strobe, `cs_rd_hi` for the read strobe and `cs_wr_hi` for the write strobe. A bit value of 1 means active-high and 0 means active-low.
- R6: With `cs_cfg_en`=0, the sub-mode comes from `glb_mode` and the per-select inputs are ignored. The data phase is then 2 clocks, and the strobes use the defaults: latch active-high, read and write active-low.
- R7: While the write strobe is active, `ad_oe`=1 and `ad_o` equals the write byte. While the read strobe is active in the data phase, `ad_oe`=0.
- R8: A read captures `ad_i` on the final clock of the active read strobe. `done` rises on the next clock, when `rdata` holds the captured byte.
- R9: In sub-modes 1 (split) and 2, reads leave `ad_oe`=0 during the address phase. Code 3 is reserved and behaves as sub-mode 1.
- R10: In sub-mode 2 (streaming read), the read strobe stays active after a read completes and through a following sub-mode-2 read. Any other access releases it before its address phase.
- R11: Changes to the configuration, address or data inputs after acceptance do not affect the running access.
- R12: `done` is a one-clock pulse. The latency from acceptance to `done` is the data-phase width plus 2 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write byte |
| cs_cfg_en | input | 1 | Use per-select settings |
| cs_mode | input | 2 | Per-select sub-mode |
| cs_rd_ws | input | 2 | Read wait-state code |
| cs_wr_ws | input | 2 | Write wait-state code |
| cs_rd_trim | input | 1 | Shorten read strobe by one clock |
| cs_wr_trim | input | 1 | Shorten write strobe by one clock |
| cs_ale_hi | input | 1 | Latch strobe active-high |
| cs_rd_hi | input | 1 | Read strobe active-high |
| cs_wr_hi | input | 1 | Write strobe active-high |
| glb_mode | input | 2 | Sub-mode when per-select settings are off |
| busy | output | 1 | Access in progress |
| done | output | 1 | Access complete pulse |
| rdata | output | DATA_W | Captured read byte |
| ale_o | output | 1 | Address-latch strobe pin level |
| rd_o | output | 1 | Read strobe pin level |
| wr_o | output | 1 | Write strobe pin level |
| addr_o | output | ADDR_W | Separate address bus |
| ad_o | output | DATA_W | Byte lane drive value |
| ad_oe | output | 1 | Byte lane output enable |
| ad_i | input | DATA_W | Byte lane input |

## Verification
The hardest situation to reach is the streaming read, where the read strobe must stay active across the idle gap and through the next access. The stimulus issues two back-to-back sub-mode-2 reads to different addresses and samples the strobe in every cycle, including the idle cycle between them. It then issues a split-mode write to show that the strobe is released. A second awkward case is a request raised while busy, together with a change to all configuration inputs. The bench drives this during the address phase of an access and checks that both the strobe widths and the idle state after done are unaffected.

// File: rtl/hb8_pkg.sv
package hb8_pkg;

    localparam int HB_WS_W = 2;

    typedef enum logic [1:0] {
        SUB_MUX    = 2'd0,
        SUB_SPLIT  = 2'd1,
        SUB_STREAM = 2'd2,
        SUB_RSVD   = 2'd3
    } sub_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_DONE = 2'd3
    } bus_state_e;

    typedef struct packed {
        sub_mode_e          mode;
        logic [HB_WS_W-1:0] rd_ws;
        logic [HB_WS_W-1:0] wr_ws;
        logic               rd_trim;
        logic               wr_trim;
        logic               ale_hi;
        logic               rd_hi;
        logic               wr_hi;
    } acc_cfg_t;

    localparam acc_cfg_t CFG_DEFAULT = '{
        mode:    SUB_SPLIT,
        rd_ws:   '0,
        wr_ws:   '0,
        rd_trim: 1'b0,
        wr_trim: 1'b0,
        ale_hi:  1'b1,
        rd_hi:   1'b0,
        wr_hi:   1'b0
    };

endpackage

// File: rtl/hb8_cfg_sel.sv
module hb8_cfg_sel
    import hb8_pkg::*;
(
    input  logic               sel_en,
    input  logic [1:0]         sel_mode,
    input  logic [HB_WS_W-1:0] sel_rd_ws,
    input  logic [HB_WS_W-1:0] sel_wr_ws,
    input  logic               sel_rd_trim,
    input  logic               sel_wr_trim,
    input  logic               sel_ale_hi,
    input  logic               sel_rd_hi,
    input  logic               sel_wr_hi,
    input  logic [1:0]         glb_mode,
    output acc_cfg_t           cfg_eff
);

    sub_mode_e raw_mode;

    always_comb begin
        raw_mode = sub_mode_e'(sel_en ? sel_mode : glb_mode);
        cfg_eff  = CFG_DEFAULT;
        if (sel_en) begin
            cfg_eff.rd_ws   = sel_rd_ws;
            cfg_eff.wr_ws   = sel_wr_ws;
            cfg_eff.rd_trim = sel_rd_trim;
            cfg_eff.wr_trim = sel_wr_trim;
            cfg_eff.ale_hi  = sel_ale_hi;
            cfg_eff.rd_hi   = sel_rd_hi;
            cfg_eff.wr_hi   = sel_wr_hi;
        end
        // reserved code falls back to the split sub-mode
        cfg_eff.mode = (raw_mode == SUB_RSVD) ? SUB_SPLIT : raw_mode;
    end

endmodule

// File: rtl/hb8_wait_cnt.sv
module hb8_wait_cnt
    import hb8_pkg::*;
#(
    parameter int WS_W = HB_WS_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [WS_W-1:0] ws,
    input  logic            trim,
    input  logic            run,
    output logic            last
);

    localparam int CNT_W = WS_W + 1;
    localparam int SUM_W = WS_W + 2;

    logic [CNT_W-1:0] cnt;
    logic [SUM_W-1:0] span_m1;

    // strobe width minus one: 2*ws + 1 - trim
    always_comb begin
        span_m1 = {1'b0, ws, 1'b0} + SUM_W'(1) - SUM_W'(trim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CNT_W'(span_m1);
        end else if (run && (cnt != '0)) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign last = (cnt == '0);

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !run) |=> $stable(cnt));

endmodule

// File: rtl/hb8_pin_drv.sv
module hb8_pin_drv
    import hb8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_state_e        st,
    input  logic              wr_q,
    input  logic              hold_q,
    input  acc_cfg_t          cfg_q,
    input  logic [DATA_W-1:0] addr_lo,
    input  logic [DATA_W-1:0] wdata_q,
    output logic              ale_o,
    output logic              rd_o,
    output logic              wr_o,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe
);

    logic ale_act;
    logic rd_act;
    logic wr_act;
    logic mux_bus;

    always_comb begin
        ale_act = (st == ST_ADDR);
        rd_act  = ((st == ST_DATA) && !wr_q) || hold_q;
        wr_act  = (st == ST_DATA) && wr_q;
        mux_bus = (cfg_q.mode == SUB_MUX);
    end

    always_comb begin
        ale_o = cfg_q.ale_hi ? ale_act : !ale_act;
        rd_o  = cfg_q.rd_hi  ? rd_act  : !rd_act;
        wr_o  = cfg_q.wr_hi  ? wr_act  : !wr_act;
    end

    always_comb begin
        ad_oe = 1'b0;
        ad_o  = '0;
        unique case (st)
            ST_ADDR: begin
                if (mux_bus) begin
                    ad_oe = 1'b1;
                    ad_o  = addr_lo;
                end else if (wr_q) begin
                    ad_oe = 1'b1;
                    ad_o  = wdata_q;
                end
            end
            ST_DATA: begin
                if (wr_q) begin
                    ad_oe = 1'b1;
                    ad_o  = wdata_q;
                end
            end
            default: begin
            end
        endcase
    end

    // R7
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_act && wr_act));

    // R7
    rd_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && (st == ST_DATA)) |-> !ad_oe);

endmodule

// File: rtl/hb8_ctrl.sv
module hb8_ctrl
    import hb8_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cs_cfg_en,
    input  logic [1:0]        cs_mode,
    input  logic [1:0]        cs_rd_ws,
    input  logic [1:0]        cs_wr_ws,
    input  logic              cs_rd_trim,
    input  logic              cs_wr_trim,
    input  logic              cs_ale_hi,
    input  logic              cs_rd_hi,
    input  logic              cs_wr_hi,
    input  logic [1:0]        glb_mode,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              ale_o,
    output logic              rd_o,
    output logic              wr_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] ad_o,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_i
);

    bus_state_e        st, st_nx;
    acc_cfg_t          cfg_eff, cfg_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              wr_q;
    logic              hold_q;
    logic              accept;
    logic              span_last;
    logic              stream_rd;

    hb8_cfg_sel u_cfg (
        .sel_en      (cs_cfg_en),
        .sel_mode    (cs_mode),
        .sel_rd_ws   (cs_rd_ws),
        .sel_wr_ws   (cs_wr_ws),
        .sel_rd_trim (cs_rd_trim),
        .sel_wr_trim (cs_wr_trim),
        .sel_ale_hi  (cs_ale_hi),
        .sel_rd_hi   (cs_rd_hi),
        .sel_wr_hi   (cs_wr_hi),
        .glb_mode    (glb_mode),
        .cfg_eff     (cfg_eff)
    );

    assign accept    = (st == ST_IDLE) && req_valid;
    assign stream_rd = (cfg_eff.mode == SUB_STREAM) && !req_write;

    hb8_wait_cnt #(.WS_W(HB_WS_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .ws    (req_write ? cfg_eff.wr_ws : cfg_eff.rd_ws),
        .trim  (req_write ? cfg_eff.wr_trim : cfg_eff.rd_trim),
        .run   (st == ST_DATA),
        .last  (span_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (req_valid) st_nx = ST_ADDR;
            ST_ADDR: st_nx = ST_DATA;
            ST_DATA: if (span_last) st_nx = ST_DONE;
            ST_DONE: st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // access context, captured at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= CFG_DEFAULT;
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
        end else if (accept) begin
            cfg_q   <= cfg_eff;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            wr_q    <= req_write;
        end
    end

    // read capture and streaming strobe hold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            hold_q  <= 1'b0;
        end else begin
            if (accept && !stream_rd) begin
                hold_q <= 1'b0;
            end else if ((st == ST_DATA) && span_last && !wr_q
                         && (cfg_q.mode == SUB_STREAM)) begin
                hold_q <= 1'b1;
            end
            if ((st == ST_DATA) && span_last && !wr_q) begin
                rdata_q <= ad_i;
            end
        end
    end

    // outputs
    always_comb begin
        busy   = (st != ST_IDLE);
        done   = (st == ST_DONE);
        rdata  = rdata_q;
        addr_o = addr_q;
    end

    hb8_pin_drv #(.DATA_W(DATA_W)) u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .st      (st),
        .wr_q    (wr_q),
        .hold_q  (hold_q),
        .cfg_q   (cfg_q),
        .addr_lo (addr_q[DATA_W-1:0]),
        .wdata_q (wdata_q),
        .ale_o   (ale_o),
        .rd_o    (rd_o),
        .wr_o    (wr_o),
        .ad_o    (ad_o),
        .ad_oe   (ad_oe)
    );

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(st) == ST_DATA));

    // R2
    no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(addr_o));

    // R3
    latch_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ADDR) |=> (st == ST_DATA));

endmodule

// File: tb/hb8_ctrl_tb.sv
`timescale 1ns/1ps
module hb8_ctrl_tb_top;

    typedef struct packed {
        logic        wr;
        logic        en;
        logic [1:0]  mode;
        logic [1:0]  rws;
        logic [1:0]  wws;
        logic        rtrim;
        logic        wtrim;
        logic        ale_hi;
        logic        rd_hi;
        logic        wr_hi;
        logic [1:0]  glb;
        logic [15:0] addr;
        logic [7:0]  wd;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0,1'b1,2'd0,2'd1,2'd0,1'b0,1'b0,1'b1,1'b0,1'b0,2'd1,16'h12A5,8'h00},
        '{1'b1,1'b1,2'd0,2'd0,2'd2,1'b0,1'b1,1'b0,1'b1,1'b1,2'd1,16'h3C5A,8'h96},
        '{1'b0,1'b1,2'd1,2'd3,2'd0,1'b1,1'b0,1'b0,1'b1,1'b0,2'd0,16'h7E01,8'h00},
        '{1'b1,1'b1,2'd1,2'd0,2'd3,1'b0,1'b0,1'b1,1'b0,1'b1,2'd0,16'h0BEE,8'h3C},
        '{1'b0,1'b0,2'd1,2'd3,2'd0,1'b1,1'b0,1'b0,1'b1,1'b1,2'd0,16'h4411,8'h00},
        '{1'b1,1'b0,2'd0,2'd0,2'd2,1'b0,1'b1,1'b0,1'b1,1'b1,2'd1,16'h5522,8'hC3},
        '{1'b0,1'b1,2'd3,2'd0,2'd0,1'b1,1'b0,1'b1,1'b0,1'b0,2'd0,16'h6633,8'h00},
        '{1'b1,1'b1,2'd2,2'd0,2'd1,1'b0,1'b0,1'b1,1'b0,1'b0,2'd0,16'h7744,8'h5A}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        cs_cfg_en = 1'b0;
    logic [1:0]  cs_mode = '0, cs_rd_ws = '0, cs_wr_ws = '0, glb_mode = '0;
    logic        cs_rd_trim = 1'b0, cs_wr_trim = 1'b0;
    logic        cs_ale_hi = 1'b0, cs_rd_hi = 1'b0, cs_wr_hi = 1'b0;
    logic        busy, done, ale_o, rd_o, wr_o, ad_oe;
    logic [7:0]  rdata, ad_o, ad_i;
    logic [15:0] addr_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    // external device model: byte derived from the address
    assign ad_i = ~addr_o[7:0] ^ addr_o[15:8];

    hb8_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .cs_cfg_en(cs_cfg_en),
        .cs_mode(cs_mode), .cs_rd_ws(cs_rd_ws), .cs_wr_ws(cs_wr_ws),
        .cs_rd_trim(cs_rd_trim), .cs_wr_trim(cs_wr_trim), .cs_ale_hi(cs_ale_hi),
        .cs_rd_hi(cs_rd_hi), .cs_wr_hi(cs_wr_hi), .glb_mode(glb_mode),
        .busy(busy), .done(done), .rdata(rdata), .ale_o(ale_o), .rd_o(rd_o),
        .wr_o(wr_o), .addr_o(addr_o), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input logic [15:0] a);
        return ~a[7:0] ^ a[15:8];
    endfunction

    function automatic int exp_width(input vec_t v);
        if (!v.en) return 2;
        if (v.wr) return 2 * (int'(v.wws) + 1) - int'(v.wtrim);
        return 2 * (int'(v.rws) + 1) - int'(v.rtrim);
    endfunction

    function automatic logic [1:0] exp_mode(input vec_t v);
        logic [1:0] m;
        m = v.en ? v.mode : v.glb;
        return (m == 2'd3) ? 2'd1 : m;
    endfunction

    task automatic apply(input vec_t v);
        req_write = v.wr; req_addr = v.addr; req_wdata = v.wd;
        cs_cfg_en = v.en; cs_mode = v.mode; cs_rd_ws = v.rws; cs_wr_ws = v.wws;
        cs_rd_trim = v.rtrim; cs_wr_trim = v.wtrim; cs_ale_hi = v.ale_hi;
        cs_rd_hi = v.rd_hi; cs_wr_hi = v.wr_hi; glb_mode = v.glb;
    endtask

    // runs one access; counts active clocks of each strobe and checks the lanes
    task automatic run_acc(input vec_t v, input bit disturb,
                           output int rdw, output int wrw, output int alew,
                           output int lat, output logic [7:0] rdat);
        logic ah, rh, wh;
        bit mux;
        ah = v.en ? v.ale_hi : 1'b1;
        rh = v.en ? v.rd_hi  : 1'b0;
        wh = v.en ? v.wr_hi  : 1'b0;
        mux = (exp_mode(v) == 2'd0);
        rdw = 0; wrw = 0; alew = 0; lat = 0; rdat = '0;
        @(negedge clk);
        apply(v);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int n = 0; n < 40; n++) begin
            lat++;
            if (disturb && n == 0) begin
                req_valid = 1'b1; req_addr = ~v.addr; req_write = ~v.wr;
                cs_rd_ws = ~v.rws; cs_wr_ws = ~v.wws; cs_ale_hi = ~v.ale_hi;
                cs_rd_hi = ~v.rd_hi; cs_wr_hi = ~v.wr_hi; cs_cfg_en = ~v.en;
            end
            if (disturb && n == 1) req_valid = 1'b0;
            if (ale_o == ah) begin
                alew++;
                chk(addr_o == v.addr, "R3 addr_o", int'(addr_o), int'(v.addr));
                if (mux)
                    chk(ad_oe && ad_o == v.addr[7:0], "R3 mux address on lane",
                        int'(ad_o), int'(v.addr[7:0]));
                else if (!v.wr)
                    chk(!ad_oe, "R9 lane idle in address phase", int'(ad_oe), 0);
            end
            if (wr_o == wh) begin
                wrw++;
                chk(ad_oe && ad_o == v.wd, "R7 write byte", int'(ad_o), int'(v.wd));
            end
            if (rd_o == rh) begin
                rdw++;
                if (!done) chk(!ad_oe, "R7 lane released on read", int'(ad_oe), 0);
            end
            if (done) begin
                rdat = rdata;
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        int rdw, wrw, alew, lat, w;
        logic [7:0] rdat;
        vec_t v;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk(busy == 0 && done == 0, "R1 busy/done", int'({busy, done}), 0);
        chk(rd_o == 1 && wr_o == 1 && ale_o == 0, "R1 strobes idle",
            int'({rd_o, wr_o, ale_o}), 6);
        chk(ad_oe == 0, "R1 lane off", int'(ad_oe), 0);
        rst_n = 1'b1;

        // table walk covers R4 R5 R6 R7 R8 R9 R12
        for (int i = 0; i < NVEC; i++) begin
            v = VECS[i];
            w = exp_width(v);
            run_acc(v, 1'b0, rdw, wrw, alew, lat, rdat);
            chk(alew == 1, "R3 latch width", alew, 1);
            if (v.wr) begin
                chk(wrw == w, "R4 write strobe width", wrw, w);
                chk(rdw == 0, "R5 read strobe idle on write", rdw, 0);
            end else begin
                chk(rdw == w, "R4 read strobe width", rdw, w);
                chk(rdat == model(v.addr), "R8 read byte", int'(rdat), int'(model(v.addr)));
            end
            chk(lat == w + 2, "R12 latency", lat, w + 2);
            @(negedge clk);
            chk(!done && !busy, "R12 single done pulse", int'({done, busy}), 0);
        end

        // R2 and R11: request and new settings raised mid-access
        v = VECS[2];
        run_acc(v, 1'b1, rdw, wrw, alew, lat, rdat);
        chk(rdw == exp_width(v), "R11 width kept", rdw, exp_width(v));
        chk(rdat == model(v.addr), "R11 read byte kept", int'(rdat), int'(model(v.addr)));
        @(negedge clk);
        chk(!busy, "R2 busy request ignored", int'(busy), 0);
        @(negedge clk);
        chk(!busy, "R2 no late access", int'(busy), 0);

        // R10 streaming reads
        v = '{1'b0,1'b1,2'd2,2'd0,2'd0,1'b0,1'b0,1'b1,1'b0,1'b0,2'd0,16'h0040,8'h00};
        run_acc(v, 1'b0, rdw, wrw, alew, lat, rdat);
        chk(rdw == 3, "R10 first stream read strobe", rdw, 3);
        @(negedge clk);
        chk(rd_o == 1'b0, "R10 strobe held while idle", int'(rd_o), 0);
        v.addr = 16'h0141;
        run_acc(v, 1'b0, rdw, wrw, alew, lat, rdat);
        chk(rdw == lat, "R10 strobe held through next read", rdw, lat);
        chk(rdat == model(16'h0141), "R10 stream read byte", int'(rdat), int'(model(16'h0141)));
        v = '{1'b1,1'b1,2'd1,2'd0,2'd0,1'b0,1'b0,1'b1,1'b0,1'b0,2'd0,16'h0242,8'hA7};
        run_acc(v, 1'b0, rdw, wrw, alew, lat, rdat);
        chk(rdw == 0, "R10 strobe released by write", rdw, 0);

        // R4 shortest strobe: code 0 with trim
        v = '{1'b1,1'b1,2'd1,2'd0,2'd0,1'b0,1'b1,1'b1,1'b0,1'b0,2'd0,16'h0303,8'h11};
        run_acc(v, 1'b0, rdw, wrw, alew, lat, rdat);
        chk(wrw == 1, "R4 trimmed one-clock write", wrw, 1);
        chk(lat == 3, "R12 shortest latency", lat, 3);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule